// File: doc/BRIEF.md
# Two-Register Sequenced Processor Core

This block is a tiny processor. It has two 4-bit working registers (A and B), an eight-function ALU, a write-back multiplexer and a state-machine sequencer. The host supplies one 9-bit instruction word together with a start strobe. The core checks the destination field, runs the operation over two or three cycles and then raises `done`.

The handshake uses the start/done pair, not a streaming interface. The host raises `start` with a stable `instr` and holds both until `done` is seen. It then drops `start`. The core leaves `done` high for as long as `start` stays high, and returns to idle one cycle after `start` falls. The core does not latch `instr`, so the word must not change while `start` is high.

An output-bus instruction copies a register onto `out_bus`, and the bus keeps that value until the next such instruction. The carry of the most recent add or subtract is kept on `carry`, so a second core can chain from it.

Top module: `tworeg_core`

## Requirements
- R1: After reset, `out_bus` is 0, `done` is 0, `carry` is 0, and both working registers read 0.
- R2: The instruction fields are code in `instr[8:6]`, immediate in `instr[5:2]` and destination in `instr[1:0]`. Destination 00 names A and 01 names B. Code 000 writes the immediate into the named register.
- R3: Code 001 copies B into A when the destination is A, and copies A into B when the destination is B.
- R4: Code 010 writes A AND B into the destination. Code 011 writes A OR B into the destination.
- R5: Code 100 writes (A + B) mod 16 into the destination, and `carry` becomes bit 4 of A + B.
- R6: Code 101 writes (B − A) mod 16 into the destination. It first replaces A with (−A) mod 16. `carry` becomes bit 4 of ((−A) mod 16) + B.
- R7: Code 110 writes A shifted right by one, with 0 filled in at the top, into the destination.
- R8: Code 111 puts the named register on `out_bus`. `out_bus` keeps its value under every other instruction.
- R9: An instruction whose destination is 10 or 11 is never executed: no register, `out_bus` or `carry` changes, and `done` stays 0.
- R10: For a valid instruction, `done` first reads 1 three clock edges after `start` is first sampled high, or four edges for code 101. `done` stays 1 while `start` is held, and goes to 0 one edge after `start` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Execute request, held until `done` |
| instr | input | 9 | Instruction word: code, immediate, destination |
| done | output | 1 | Instruction complete |
| out_bus | output | 4 | Registered output bus |
| carry | output | 1 | Carry from the last add or subtract |

## Verification
The bench sweeps every pair of register values through every arithmetic and logic instruction, with both destinations.

- Subtract is the most likely corner to go wrong. A design that skips or misorders the negate step gives A − B or A + B. A design that restores A leaves A unchanged, where a correct design leaves it negated.
- A transfer with the roles swapped would copy the destination onto itself.
- A destination decode that lets the 1x codes through would load or overwrite a register. It would also raise `done` on a malformed word.
- Latency is measured on every instruction. An extra or missing state, or `done` dropping while `start` is still held, breaks the handshake count.

// File: rtl/tworeg_pkg.sv
package tworeg_pkg;
  typedef enum logic [2:0] {
    ALU_NEG  = 3'd0,
    ALU_AND  = 3'd1,
    ALU_OR   = 3'd2,
    ALU_ADD  = 3'd3,
    ALU_PA   = 3'd4,
    ALU_PB   = 3'd5,
    ALU_SLL  = 3'd6,
    ALU_SRL  = 3'd7
  } alu_op_t;

  localparam logic [2:0] OPC_LOAD = 3'b000;
  localparam logic [2:0] OPC_XFER = 3'b001;
  localparam logic [2:0] OPC_AND  = 3'b010;
  localparam logic [2:0] OPC_OR   = 3'b011;
  localparam logic [2:0] OPC_ADD  = 3'b100;
  localparam logic [2:0] OPC_SUB  = 3'b101;
  localparam logic [2:0] OPC_SHR  = 3'b110;
  localparam logic [2:0] OPC_EMIT = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEC  = 3'd1,
    ST_NEG  = 3'd2,
    ST_EXEC = 3'd3,
    ST_FIN  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/tworeg_alu.sv
module tworeg_alu
  import tworeg_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  alu_op_t       op,
  output logic [DW-1:0] f,
  output logic          cout
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};
  logic [DW:0] sum;

  always_comb begin
    sum  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    f    = '0;
    cout = 1'b0;
    case (op)
      ALU_NEG: f = (~a) + ONE;
      ALU_AND: f = a & b;
      ALU_OR:  f = a | b;
      ALU_ADD: begin f = sum[DW-1:0]; cout = sum[DW]; end
      ALU_PA:  f = a;
      ALU_PB:  f = b;
      ALU_SLL: f = {a[DW-2:0], 1'b0};
      ALU_SRL: f = {1'b0, a[DW-1:1]};
      default: f = '0;
    endcase
  end
endmodule

// File: rtl/tworeg_datapath.sv
module tworeg_datapath
  import tworeg_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] imm,
  input  logic          sel_imm,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic          wr_out,
  input  alu_op_t       op,
  input  logic          cin,
  output logic [DW-1:0] out_q,
  output logic          cout
);
  logic [DW-1:0] reg_a, reg_b, alu_f, wdata;

  tworeg_alu #(.DW(DW)) u_alu (
    .a(reg_a), .b(reg_b), .cin(cin), .op(op), .f(alu_f), .cout(cout)
  );

  assign wdata = sel_imm ? imm : alu_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
      out_q <= '0;
    end else begin
      if (wr_a)   reg_a <= wdata;
      if (wr_b)   reg_b <= wdata;
      if (wr_out) out_q <= alu_f;
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_out |=> $stable(out_q));
endmodule

// File: rtl/tworeg_ctrl.sv
module tworeg_ctrl
  import tworeg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] code,
  input  logic [1:0] dest,
  input  logic       cout,
  output alu_op_t    op,
  output logic       cin,
  output logic       sel_imm,
  output logic       wr_a,
  output logic       wr_b,
  output logic       wr_out,
  output logic       done,
  output logic       carry
);
  seq_state_t state, nxt;
  logic malformed, to_b;

  assign malformed = dest[1];
  assign to_b      = dest[0];
  assign done      = (state == ST_FIN);

  always_comb begin
    nxt     = state;
    op      = ALU_PA;
    cin     = 1'b0;
    sel_imm = 1'b0;
    wr_a    = 1'b0;
    wr_b    = 1'b0;
    wr_out  = 1'b0;
    case (state)
      ST_IDLE: if (start) nxt = ST_DEC;
      ST_DEC: begin
        if (malformed) begin
          if (!start) nxt = ST_IDLE;
        end else if (code == OPC_SUB) nxt = ST_NEG;
        else nxt = ST_EXEC;
      end
      ST_NEG: begin
        op   = ALU_NEG;
        wr_a = 1'b1;
        nxt  = ST_EXEC;
      end
      ST_EXEC: begin
        nxt  = ST_FIN;
        wr_a = !to_b;
        wr_b = to_b;
        case (code)
          OPC_LOAD: sel_imm = 1'b1;
          OPC_XFER: op = to_b ? ALU_PA : ALU_PB;
          OPC_AND:  op = ALU_AND;
          OPC_OR:   op = ALU_OR;
          OPC_ADD,
          OPC_SUB:  op = ALU_ADD;
          OPC_SHR:  op = ALU_SRL;
          default: begin
            op     = to_b ? ALU_PB : ALU_PA;
            wr_a   = 1'b0;
            wr_b   = 1'b0;
            wr_out = 1'b1;
          end
        endcase
      end
      ST_FIN: if (!start) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      carry <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_EXEC && (code == OPC_ADD || code == OPC_SUB))
        carry <= cout;
    end
  end

  // R9
  malformed_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEC && malformed) |=> (state == ST_DEC || state == ST_IDLE));
  // R6
  sub_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEG) |=> (state == ST_EXEC));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);
  // R10
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);
  // R2
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_a, wr_b, wr_out}));
endmodule

// File: rtl/tworeg_core.sv
module tworeg_core
  import tworeg_pkg::*;
#(
  parameter int DW = 4,
  localparam int IW = 3 + DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] instr,
  output logic          done,
  output logic [DW-1:0] out_bus,
  output logic          carry
);
  alu_op_t op;
  logic cin, sel_imm, wr_a, wr_b, wr_out, cout;

  tworeg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .code(instr[IW-1:IW-3]), .dest(instr[1:0]), .cout(cout),
    .op(op), .cin(cin), .sel_imm(sel_imm), .wr_a(wr_a), .wr_b(wr_b),
    .wr_out(wr_out), .done(done), .carry(carry)
  );

  tworeg_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .imm(instr[DW+1:2]), .sel_imm(sel_imm),
    .wr_a(wr_a), .wr_b(wr_b), .wr_out(wr_out), .op(op), .cin(cin),
    .out_q(out_bus), .cout(cout)
  );
endmodule

// File: tb/tworeg_core_test.sv
`timescale 1ns/1ps
module tworeg_core_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [8:0] instr = '0;
  logic done, carry;
  logic [3:0] out_bus;
  int n_run = 0, n_fail = 0;
  int ma = 0, mb = 0, mout = 0, mcarry = 0;

  always #2.5 clk = ~clk;

  tworeg_core uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .done(done), .out_bus(out_bus), .carry(carry)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] c, input int imm, input int d, input string req);
    int lat, expl;
    lat = 0;
    expl = (c == 3'b101) ? 4 : 3;
    instr = {c, imm[3:0], d[1:0]};
    start = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (done) begin lat = i; break; end
    end
    chk(lat == expl, {req, "/R10 latency"}, lat, expl);
    @(negedge clk);
    chk(done == 1'b1, "R10 done held", int'(done), 1);
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R10 done drop", int'(done), 0);
  endtask

  task automatic emit(input int d, input string req);
    run(3'b111, 0, d, req);
    mout = (d == 0) ? ma : mb;
    chk(int'(out_bus) == mout, req, int'(out_bus), mout);
  endtask

  task automatic load(input int v, input int d);
    run(3'b000, v, d, "R2");
    if (d == 0) ma = v; else mb = v;
  endtask

  task automatic apply(input logic [2:0] c, input int d);
    int r, a0;
    a0 = ma;
    case (c)
      3'b001: r = (d == 0) ? mb : ma;
      3'b010: r = ma & mb;
      3'b011: r = ma | mb;
      3'b100: begin r = (ma + mb) & 15; mcarry = (ma + mb) >> 4; end
      3'b101: begin
        ma = (16 - a0) & 15;
        r = (mb + ma) & 15;
        mcarry = (mb + ma) >> 4;
      end
      default: r = ma >> 1;
    endcase
    run(c, 0, d, "R3-op");
    if (d == 0) ma = r; else mb = r;
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_bus == 4'd0, "R1 out_bus", int'(out_bus), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(carry == 1'b0, "R1 carry", int'(carry), 0);
    rst_n = 1'b1;
    @(negedge clk);
    emit(1, "R1 regB");
    emit(0, "R1 regA");

    // R8 output holds across other instructions
    load(9, 0);
    emit(0, "R8 emit");
    load(3, 0);
    chk(int'(out_bus) == 9, "R8 hold after load", int'(out_bus), 9);
    load(5, 1);
    run(3'b100, 0, 1, "R5");
    mb = 8; mcarry = 0;
    chk(int'(out_bus) == 9, "R8 hold after add", int'(out_bus), 9);

    // R9 malformed words: no effect, no done
    for (int k = 0; k < 16; k++) begin
      int dd;
      dd = 2 + (k & 1);
      instr = {k[2:0], 4'hF, dd[1:0]};
      start = 1'b1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(done == 1'b0, "R9 done", int'(done), 0);
      end
      start = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
    chk(int'(out_bus) == 9, "R9 out_bus", int'(out_bus), 9);
    chk(int'(carry) == mcarry, "R9 carry", int'(carry), mcarry);
    emit(0, "R9 regA kept");
    emit(1, "R9 regB kept");

    // Exhaustive sweep: R3 R4 R5 R6 R7
    for (int ci = 1; ci <= 6; ci++) begin
      case (ci)
        1: tag = "R3";
        2, 3: tag = "R4";
        4: tag = "R5";
        5: tag = "R6";
        default: tag = "R7";
      endcase
      for (int d = 0; d < 2; d++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            load(a, 0);
            load(b, 1);
            apply(ci[2:0], d);
            emit(d, tag);
            if (ci == 4 || ci == 5)
              chk(int'(carry) == mcarry, {tag, " carry"}, int'(carry), mcarry);
            if (ci == 5 && d == 1) emit(0, "R6 A negated");
          end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule